// File: doc/BRIEF.md
# Counter-Addressed Sine Wave Table Generator

This block produces a periodic 8-bit sine waveform by stepping through a fixed lookup table. A 4-bit synchronous up-counter supplies the low four bits of a 12-bit table address. The upper eight address bits are held at all ones. The counter therefore sweeps a 16-word window at the top of a 4096-word read-only table, from address 0xFF0 to 0xFFF, and then wraps back to 0xFF0.

That window holds one full sine cycle of 16 samples in offset binary: 0x00 is the lowest level and 0xFF is the highest. The samples are meant for an external digital-to-analog converter. With the count enable held high, the sample period is 16 clocks, so the waveform frequency is the clock frequency divided by 16.

All bits of the counter share one clock. Each bit behaves as a toggle stage, enabled by a serial AND chain of the enable and the lower bits. Dropping the enable freezes both the count and the sample. An active-low asynchronous clear returns the count to zero. A carry-out marks the cycle in which the count will wrap. The carry-out plays no part in addressing the table.

The sample and count are plain continuous outputs with no valid/ready handshake. A new value appears after every enabled clock edge and cannot be stalled from downstream other than through the enable.

Top module: `sinegen_top`

## Requirements
- R1: While `clr_n` is low, `count` is 0 and `sample` is 128 (0x80). This takes effect without waiting for a clock edge.
- R2: With `en` high, `count` advances by one on every rising edge of `clk`, and wraps from 15 to 0.
- R3: With `en` low, `count` and `sample` keep their values across rising edges of `clk`.
- R4: `carry` is 1 exactly when `en` is 1 and `count` is 15. It is 0 in every other case.
- R5: `sample` is the table word at address {8'hFF, count}. For count values 0 through 15 this gives 128, 176, 218, 245, 255, 245, 218, 176, 128, 79, 37, 10, 0, 10, 37, 79. Each value is round(127.5 + 127.5·sin(2πk/16)).
- R6: With `en` held high, the sample sequence repeats with a period of exactly 16 clocks, and the peak value 255 appears once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter changes only on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| en | input | 1 | Count enable; low freezes the count |
| sample | output | 8 | Current sine sample, offset binary |
| count | output | 4 | Current counter value (low table address bits) |
| carry | output | 1 | Counter carry-out: enable high at count 15 |

## Verification
The main function is driven with four input patterns:
- A long run with the enable always high. The sample stream is compared word by word with a reference table over two full periods, which separates a wrong table entry or address from a wrong period.
- An enable that toggles every other clock. This shows whether a stalled edge leaks a step or drops one.
- A long hold with the enable low. This catches a counter that ignores the freeze.
- A clear applied in the middle of a count. This checks that the asynchronous return to address 0xFF0 acts without a clock edge, and that counting resumes cleanly from zero. The carry is sampled at count 15 both with and without the enable, which tells the carry term apart from the count value alone.

// File: rtl/sinegen_pkg.sv
package sinegen_pkg;

  localparam int unsigned SAMPLE_W = 8;
  localparam int unsigned STEP_W   = 4;
  localparam int unsigned ADDR_W   = 12;

  // One sine cycle of 2**STEP_W points, built by quarter-wave symmetry.
  // Magnitude above mid-scale for quarter positions 0..4.
  function automatic logic [SAMPLE_W-1:0] sine_at(input logic [STEP_W-1:0] k);
    logic [2:0] pos;
    logic [6:0] mag;
    pos = k[2] ? (3'd4 - {1'b0, k[1:0]}) : {1'b0, k[1:0]};
    if (k[2:0] == 3'd4) pos = 3'd4;
    case (pos)
      3'd0:    mag = 7'd0;
      3'd1:    mag = 7'd48;
      3'd2:    mag = 7'd90;
      3'd3:    mag = 7'd117;
      default: mag = 7'd127;
    endcase
    if (!k[3])          sine_at = 8'd128 + {1'b0, mag};
    else if (pos == 0)  sine_at = 8'd128;
    else                sine_at = 8'd127 - {1'b0, mag};
  endfunction

endpackage

// File: rtl/sinegen_counter.sv
module sinegen_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             en,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  // toggle enables, serial AND chain from the enable upward
  logic [WIDTH-1:0] tog;

  assign tog[0] = en;

  genvar i;
  generate
    for (i = 1; i < WIDTH; i++) begin : g_chain
      assign tog[i] = tog[i-1] & q[i-1];
    end
    for (i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      q[i] <= 1'b0;
        else if (tog[i]) q[i] <= ~q[i];
      end
    end
  endgenerate

  assign carry = tog[WIDTH-1] & q[WIDTH-1];

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    en |=> q == WIDTH'($past(q) + 1'b1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !en |=> $stable(q));

endmodule

// File: rtl/sinegen_table.sv
module sinegen_table
  import sinegen_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned LW   = STEP_W,
  parameter logic [SAMPLE_W-1:0] FILL = '0
) (
  input  logic [AW-1:0]       addr,
  output logic [SAMPLE_W-1:0] data
);

  // Only the topmost 2**LW words carry the waveform
  logic in_window;
  assign in_window = &addr[AW-1:LW];

  always_comb begin
    if (in_window) data = sine_at(addr[LW-1:0]);
    else           data = FILL;
  end

endmodule

// File: rtl/sinegen_top.sv
module sinegen_top
  import sinegen_pkg::*;
(
  input  logic                clk,
  input  logic                clr_n,
  input  logic                en,
  output logic [SAMPLE_W-1:0] sample,
  output logic [STEP_W-1:0]   count,
  output logic                carry
);

  localparam int unsigned HI_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] addr;

  sinegen_counter #(.WIDTH(STEP_W)) u_cnt (
    .clk   (clk),
    .clr_n (clr_n),
    .en    (en),
    .q     (count),
    .carry (carry)
  );

  assign addr = {{HI_W{1'b1}}, count};

  sinegen_table #(.AW(ADDR_W), .LW(STEP_W)) u_tab (
    .addr (addr),
    .data (sample)
  );

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry |=> count == '0);

  // R4
  carry_idle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !en |-> !carry);

  // R5
  peak_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (count == STEP_W'(4)) |-> sample == 8'd255);

  // R3
  sample_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !en |=> $stable(sample));

endmodule

// File: tb/sinegen_top_test.sv
module sinegen_top_test;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] sample;
  logic [3:0] count;
  logic       carry;

  int n_run  = 0;
  int n_fail = 0;
  int ref_tab [16];
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  sinegen_top uut (
    .clk(clk), .clr_n(clr_n), .en(en),
    .sample(sample), .count(count), .carry(carry)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clk_step();
    @(posedge clk); #1;
  endtask

  task automatic check_all(input string req);
    chk({req, " count"}, int'(count), exp_cnt);
    chk({req, " sample"}, int'(sample), ref_tab[exp_cnt]);
    chk({req, " carry"}, int'(carry), (en && exp_cnt == 15) ? 1 : 0);
  endtask

  // R1: clear state
  task automatic t_reset();
    clr_n = 1'b0; en = 1'b0; #3;
    exp_cnt = 0;
    chk("R1 count", int'(count), 0);
    chk("R1 sample", int'(sample), 128);
    clk_step(); clr_n = 1'b1;
  endtask

  // R2 R5 R6: free run over two periods
  task automatic t_free_run();
    int first [16];
    en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      check_all("R5");
      if (i < 16) first[i] = int'(sample);
      else chk("R6 period", int'(sample), first[i-16]);
      clk_step();
      exp_cnt = (exp_cnt + 1) % 16;
    end
    check_all("R2 wrap");
  endtask

  // R3: hold while disabled
  task automatic t_hold();
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin clk_step(); exp_cnt = (exp_cnt + 1) % 16; end
    en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      clk_step();
      check_all("R3 hold");
    end
  endtask

  // R2 R3: alternate enable
  task automatic t_alt();
    for (int i = 0; i < 20; i++) begin
      en = i[0];
      clk_step();
      if (i[0]) exp_cnt = (exp_cnt + 1) % 16;
      check_all("R2 alt");
    end
  endtask

  // R4: carry with and without enable at count 15
  task automatic t_carry();
    en = 1'b1;
    while (exp_cnt != 15) begin clk_step(); exp_cnt = (exp_cnt + 1) % 16; end
    #1; chk("R4 carry en", int'(carry), 1);
    en = 1'b0; #1;
    chk("R4 carry no en", int'(carry), 0);
    chk("R4 count", int'(count), 15);
    en = 1'b1; clk_step(); exp_cnt = 0;
    check_all("R4 after wrap");
  endtask

  // R1: asynchronous clear mid count
  task automatic t_mid_clear();
    en = 1'b1;
    for (int i = 0; i < 6; i++) begin clk_step(); exp_cnt = (exp_cnt + 1) % 16; end
    #0.5 clr_n = 1'b0; #0.5;
    chk("R1 async count", int'(count), 0);
    chk("R1 async sample", int'(sample), 128);
    exp_cnt = 0;
    @(negedge clk); clr_n = 1'b1;
    clk_step(); exp_cnt = 1;
    check_all("R1 resume");
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      real v;
      v = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * k / 16.0) + 0.5;
      ref_tab[k] = $rtoi(v);
      if (ref_tab[k] > 255) ref_tab[k] = 255;
      if (ref_tab[k] < 0) ref_tab[k] = 0;
    end
    t_reset();
    t_free_run();
    t_hold();
    t_alt();
    t_carry();
    t_mid_clear();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule